// File: doc/BRIEF.md
# Multi-mode PWM timer with dead-time pair

This block is a counter-based pulse-width modulator for motor and power-stage control. One counter runs in one of three counting styles: it can wrap over its full range, wrap at a programmed period, or run up to the period and back down to zero. Each output channel compares the count with its own threshold. Its compare mode code decides which event sets the pin and which event clears it. The two choices are edge-aligned pulses, where one edge falls on the threshold match and the other on the return to zero, and centre-aligned pulses, where the direction of the count at the match picks the edge.

A prescaler slows the count by 1, 8, 32 or 128. Software writes the control word, the period, the thresholds and the mode codes through a simple write port, and the current count can be read back. Period and threshold writes wait in pending registers. They become active only when the counter passes zero, or straight away while the counter is stopped, so a running waveform never shows a mixed cycle. In up/down counting, two channels in opposite centre modes make a pin pair for an H-bridge. The span in which both pins are low is set only by the difference between the two thresholds.

Top module: `pwmt_top`

## Requirements
- R1: Count mode code 0 (control word bits [1:0]) stops the timer. It holds the count at 0 and both pins low, from reset and whenever 0 is written.
- R2: Count mode code 2 (modulo) counts 0,1,...,P and back to 0, where P is the period register at address 1. The PWM period is P+1 timer ticks.
- R3: Compare mode code 6 (channel k mode at address 4+k, bits [2:0]) sets the pin on a threshold match and clears it when the count is 0. In modulo mode the pin is high for P+1-C ticks, where C is the threshold at address 2+k.
- R4: Compare mode code 7 is the inverse of code 6. It clears the pin on a match and sets it at count 0, so in modulo mode the pin is high for C ticks.
- R5: The divider code in control bits [3:2] takes the values 0..3 and gives one timer tick every 1, 8, 32 or 128 clocks. The count changes only on a tick.
- R6: Count mode code 1 (free-running) steps through every value from 0x0000 to 0xFFFF and wraps to 0.
- R7: Count mode code 3 (up/down) counts up to P, turns and counts down to 0, for a period of 2P ticks.
- R8: Compare mode code 4 sets the pin on a match while counting up and clears it on a match while counting down, giving a high time of 2(P-C). Code 5 does the opposite, giving a high time of 2C.
- R9: With channel 1 in code 4 at threshold C1 and channel 2 in code 5 at threshold C2 < C1, both pins stay low for C1-C2 ticks on each side of every pulse.
- R10: In up/down mode with unequal thresholds, the two pins never change on the same clock edge.
- R11: A period or threshold write made while the timer runs takes effect only at the next count-0 tick. A write made while the timer is stopped takes effect at once.
- R12: Compare mode codes 0 to 3 hold the channel pin low while the counter runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 period, 2..3 thresholds, 4..5 compare modes |
| wr_data | input | 16 | Register write data |
| pwm_o | output | 2 | PWM pins, bit 0 is channel 1 |
| cnt_o | output | 16 | Current count |

## Verification
The case hardest to reach from the ports is a threshold write that lands in the middle of a running period. It has to arrive after the zero crossing and before the old match, so that a write taking effect at once would visibly change the pulse. The stimulus polls the count readout until the count reaches a known mid-period value and then writes the new threshold. It expects the pulse already in progress to keep its old width and the next pulse to take the new one. For the dead-time pair, the bench measures both-low spans on both sides of the pulse and watches for edges that fall on the same clock.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
   // counting styles, control word bits [1:0]
   localparam logic [1:0] CM_STOP = 2'd0;
   localparam logic [1:0] CM_FREE = 2'd1;
   localparam logic [1:0] CM_MOD  = 2'd2;
   localparam logic [1:0] CM_UPDN = 2'd3;

   // per-channel compare behaviours
   localparam logic [2:0] OC_CTR_UPSET = 3'd4;
   localparam logic [2:0] OC_CTR_DNSET = 3'd5;
   localparam logic [2:0] OC_EDGE_SET  = 3'd6;
   localparam logic [2:0] OC_EDGE_CLR  = 3'd7;

   // log2 of the divide ratio for each divider code
   function automatic int unsigned div_shift(input logic [1:0] sel);
      case (sel)
         2'd0:    return 0;
         2'd1:    return 3;
         2'd2:    return 5;
         default: return 7;
      endcase
   endfunction
endpackage

// File: rtl/pwmt_prescale.sv
module pwmt_prescale #(
   parameter int PRE_W = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] div_sel,
   output logic       tick
);
   import pwmt_pkg::*;

   generate
      if (PRE_W < 7) begin : g_bad_w
         $error("pwmt_prescale: PRE_W must cover a divide by 128");
      end
   endgenerate

   logic [PRE_W-1:0] pcnt;
   logic [PRE_W-1:0] lim;

   always_comb lim = PRE_W'((32'd1 << div_shift(div_sel)) - 32'd1);

   always_ff @(posedge clk) begin
      if (!rst_n)          pcnt <= '0;
      else if (!run)       pcnt <= '0;
      else if (pcnt >= lim) pcnt <= '0;
      else                 pcnt <= pcnt + 1'b1;
   end

   assign tick = run && (pcnt >= lim);
endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [1:0]       cmode,
   input  logic [CNT_W-1:0] per,
   output logic [CNT_W-1:0] cnt,
   output logic             up,
   output logic             zero_evt
);
   import pwmt_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n || cmode == CM_STOP) begin
         cnt <= '0;
         up  <= 1'b1;
      end else if (tick) begin
         case (cmode)
            CM_FREE: begin
               cnt <= cnt + 1'b1;
               up  <= 1'b1;
            end
            CM_MOD: begin
               cnt <= (cnt >= per) ? '0 : cnt + 1'b1;
               up  <= 1'b1;
            end
            default: begin
               if (per == '0) begin
                  cnt <= '0;
                  up  <= 1'b1;
               end else if (up) begin
                  if (cnt >= per) begin
                     up  <= 1'b0;
                     cnt <= cnt - 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end else if (cnt == '0) begin
                  up  <= 1'b1;
                  cnt <= cnt + 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
         endcase
      end
   end

   assign zero_evt = tick && (cnt == '0);

   a_r2_mod_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cmode == CM_MOD && cnt >= per) |=> (cnt == '0));
   a_r6_free_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cmode == CM_FREE && cnt == '1) |=> (cnt == '0));
   a_r5_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && cmode != CM_STOP) |=> $stable(cnt));
   a_r7_turn_at_top: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cmode == CM_UPDN && up && per != '0 && cnt >= per) |=> !up);
endmodule

// File: rtl/pwmt_regs.sv
module pwmt_regs #(
   parameter int CNT_W  = 16,
   parameter int N_CH   = 2,
   parameter int ADDR_W = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [CNT_W-1:0]           wr_data,
   input  logic                       load,
   output logic [1:0]                 cmode,
   output logic [1:0]                 div_sel,
   output logic [CNT_W-1:0]           per_act,
   output logic [N_CH-1:0][CNT_W-1:0] cmp_act,
   output logic [N_CH-1:0][2:0]       ocm
);
   localparam int CMP_BASE = 2;
   localparam int OCM_BASE = CMP_BASE + N_CH;

   logic [CNT_W-1:0] per_pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmode   <= '0;
         div_sel <= '0;
         per_pend <= '0;
         per_act  <= '0;
      end else begin
         if (wr_en && wr_addr == ADDR_W'(0)) begin
            cmode   <= wr_data[1:0];
            div_sel <= wr_data[3:2];
         end
         if (wr_en && wr_addr == ADDR_W'(1)) per_pend <= wr_data;
         if (load) per_act <= per_pend;
      end
   end

   for (genvar k = 0; k < N_CH; k++) begin : g_ch
      logic [CNT_W-1:0] cmp_pend;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cmp_pend   <= '0;
            cmp_act[k] <= '0;
            ocm[k]     <= '0;
         end else begin
            if (wr_en && wr_addr == ADDR_W'(CMP_BASE + k)) cmp_pend <= wr_data;
            if (wr_en && wr_addr == ADDR_W'(OCM_BASE + k)) ocm[k] <= wr_data[2:0];
            if (load) cmp_act[k] <= cmp_pend;
         end
      end

      a_r11_cmp_shadow: assert property (@(posedge clk) disable iff (!rst_n)
         !load |=> $stable(cmp_act[k]));
   end

   a_r11_per_shadow: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(per_act));
endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stop,
   input  logic             tick,
   input  logic             up,
   input  logic             zero_evt,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp,
   input  logic [2:0]       ocm,
   output logic             pwm
);
   import pwmt_pkg::*;

   logic match;
   assign match = tick && (cnt == cmp);

   // a match takes precedence over the zero event
   always_ff @(posedge clk) begin
      if (!rst_n || stop) begin
         pwm <= 1'b0;
      end else begin
         case (ocm)
            OC_CTR_UPSET: if (match) pwm <= up;
            OC_CTR_DNSET: if (match) pwm <= !up;
            OC_EDGE_SET: begin
               if (match)         pwm <= 1'b1;
               else if (zero_evt) pwm <= 1'b0;
            end
            OC_EDGE_CLR: begin
               if (match)         pwm <= 1'b0;
               else if (zero_evt) pwm <= 1'b1;
            end
            default: pwm <= 1'b0;
         endcase
      end
   end

   a_r1_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !pwm);
   a_r3_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop && match && ocm == OC_EDGE_SET) |=> pwm);
   a_r4_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop && match && ocm == OC_EDGE_CLR) |=> !pwm);
   a_r8_centre_dir: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop && match && ocm == OC_CTR_UPSET) |=> (pwm == $past(up)));
   a_r12_unused_low: assert property (@(posedge clk) disable iff (!rst_n)
      (ocm < OC_CTR_UPSET) |=> !pwm);
endmodule

// File: rtl/pwmt_top.sv
module pwmt_top #(
   parameter int CNT_W  = 16,
   parameter int N_CH   = 2,
   parameter int ADDR_W = 3,
   parameter int PRE_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [N_CH-1:0]   pwm_o,
   output logic [CNT_W-1:0]  cnt_o
);
   import pwmt_pkg::*;

   localparam int N_REGS = 2 + 2 * N_CH;

   generate
      if (CNT_W < 4) begin : g_bad_cnt
         $error("pwmt_top: CNT_W must hold the control fields");
      end
      if (N_CH < 1) begin : g_bad_ch
         $error("pwmt_top: at least one channel is needed");
      end
      if (N_REGS > (1 << ADDR_W)) begin : g_bad_addr
         $error("pwmt_top: ADDR_W too narrow for the register set");
      end
   endgenerate

   logic [1:0]                 cmode;
   logic [1:0]                 div_sel;
   logic [CNT_W-1:0]           per_act;
   logic [N_CH-1:0][CNT_W-1:0] cmp_act;
   logic [N_CH-1:0][2:0]       ocm;
   logic                       tick, up, zero_evt, stop, load;
   logic [CNT_W-1:0]           cnt;

   assign stop = (cmode == CM_STOP);
   assign load = stop || zero_evt;

   pwmt_regs #(.CNT_W(CNT_W), .N_CH(N_CH), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .load(load), .cmode(cmode), .div_sel(div_sel),
      .per_act(per_act), .cmp_act(cmp_act), .ocm(ocm)
   );

   pwmt_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(!stop), .div_sel(div_sel), .tick(tick)
   );

   pwmt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cmode(cmode), .per(per_act),
      .cnt(cnt), .up(up), .zero_evt(zero_evt)
   );

   for (genvar k = 0; k < N_CH; k++) begin : g_out
      pwmt_channel #(.CNT_W(CNT_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .stop(stop), .tick(tick), .up(up),
         .zero_evt(zero_evt), .cnt(cnt), .cmp(cmp_act[k]), .ocm(ocm[k]),
         .pwm(pwm_o[k])
      );
   end

   assign cnt_o = cnt;

   if (N_CH >= 2) begin : g_pair_chk
      a_r10_no_shared_edge: assert property (@(posedge clk) disable iff (!rst_n)
         (cmode == CM_UPDN && $past(cmode == CM_UPDN) && $past(cmp_act[0] != cmp_act[1]))
         |-> !((pwm_o[0] != $past(pwm_o[0])) && (pwm_o[1] != $past(pwm_o[1]))));
   end
endmodule

// File: tb/pwmt_top_test.sv
module pwmt_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  pwm;
   logic [15:0] cnt;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   pwmt_top uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pwm_o(pwm), .cnt_o(cnt)
   );

   // kinds: 0 high width, 1 period, 2 both-low span, 3 highs in window, 4 shared edges in window
   typedef struct {
      string req;
      int    kind;
      int    pin;
      int    expv;
      int    win;
   } item_t;

   item_t q[$];
   bit    mon_busy = 1'b0;

   task automatic check(input string req, input int act, input int expv);
      checks++;
      if (act != expv) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic push(input string req, input int kind, input int pin, input int expv, input int win);
      item_t it;
      it.req = req; it.kind = kind; it.pin = pin; it.expv = expv; it.win = win;
      q.push_back(it);
   endtask

   task automatic drain();
      @(negedge clk);
      while (q.size() != 0 || mon_busy) @(negedge clk);
   endtask

   task automatic wr(input int addr, input int data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 16'(data);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // control word: [1:0] count mode, [3:2] divider code
   task automatic cfg(input int per, input int c1, input int c2, input int m1, input int m2,
                      input int cm, input int dv);
      wr(0, 0);
      wr(1, per); wr(2, c1); wr(3, c2); wr(4, m1); wr(5, m2);
      wr(0, (dv << 2) | cm);
   endtask

   task automatic measure(input item_t it, output int n);
      logic [1:0] prev;
      n = 0;
      case (it.kind)
         0: begin
            while (pwm[it.pin]) @(negedge clk);
            while (!pwm[it.pin]) @(negedge clk);
            while (pwm[it.pin]) begin n++; @(negedge clk); end
         end
         1: begin
            while (pwm[it.pin]) @(negedge clk);
            while (!pwm[it.pin]) @(negedge clk);
            while (pwm[it.pin]) begin n++; @(negedge clk); end
            while (!pwm[it.pin]) begin n++; @(negedge clk); end
         end
         2: begin
            while (pwm == 2'b00) @(negedge clk);
            while (pwm != 2'b00) @(negedge clk);
            while (pwm == 2'b00) begin n++; @(negedge clk); end
         end
         3: begin
            for (int i = 0; i < it.win; i++) begin
               if (pwm[it.pin]) n++;
               @(negedge clk);
            end
         end
         default: begin
            prev = pwm;
            for (int i = 0; i < it.win; i++) begin
               @(negedge clk);
               if (pwm[0] != prev[0] && pwm[1] != prev[1]) n++;
               prev = pwm;
            end
         end
      endcase
   endtask

   // monitor: pops expected items and compares them with what the pins do
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() != 0) begin
            item_t it;
            int n;
            it = q.pop_front();
            mon_busy = 1'b1;
            measure(it, n);
            check(it.req, n, it.expv);
            mon_busy = 1'b0;
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int a;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 reset pins", int'(pwm), 0);
      check("R1 reset count", int'(cnt), 0);

      // modulo, period 9: ch1 code 6 thr 3, ch2 code 7 thr 4
      cfg(9, 3, 4, 6, 7, 2, 0);
      push("R2 modulo period", 1, 0, 10, 0);
      push("R3 code6 width", 0, 0, 7, 0);
      push("R4 code7 width", 0, 1, 4, 0);
      drain();

      // R1: stop while running
      wr(0, 0);
      repeat (3) @(negedge clk);
      check("R1 stop pins", int'(pwm), 0);
      check("R1 stop count", int'(cnt), 0);

      // R5: divide by 8 in modulo, period 3 -> 4 ticks
      cfg(3, 1, 0, 6, 0, 2, 1);
      push("R5 div8 period", 1, 0, 32, 0);
      push("R5 div8 width", 0, 0, 24, 0);
      drain();

      // R5: readout steps over fixed windows
      cfg(0, 0, 0, 0, 0, 1, 2);
      repeat (5) @(negedge clk);
      a = int'(cnt);
      repeat (160) @(negedge clk);
      check("R5 div32 steps", int'(cnt) - a, 5);
      wr(0, (3 << 2) | 1);
      repeat (3) @(negedge clk);
      a = int'(cnt);
      repeat (384) @(negedge clk);
      check("R5 div128 steps", int'(cnt) - a, 3);

      // R12: unused compare code keeps pin low
      cfg(9, 3, 3, 6, 2, 2, 0);
      push("R12 code2 low", 3, 1, 0, 50);
      push("R12 partner runs", 0, 0, 7, 0);
      drain();

      // R11: threshold write mid-period
      cfg(99, 90, 0, 6, 0, 2, 0);
      while (cnt != 16'd20) @(negedge clk);
      wr(2, 50);
      push("R11 old width kept", 0, 0, 10, 0);
      push("R11 new width", 0, 0, 50, 0);
      drain();

      // R7..R10: up/down pair
      cfg(40, 30, 22, 4, 5, 3, 0);
      while (cnt != 16'd40) @(negedge clk);
      @(negedge clk);
      check("R7 turn at top", int'(cnt), 39);
      push("R7 updown period", 1, 0, 80, 0);
      push("R8 code4 width", 0, 0, 20, 0);
      push("R8 code5 width", 0, 1, 44, 0);
      push("R9 dead span a", 2, 0, 8, 0);
      push("R9 dead span b", 2, 0, 8, 0);
      push("R10 shared edges", 4, 0, 0, 300);
      drain();

      // R6: free-run wrap, code 6 near the top
      cfg(0, 16'hFFF0, 0, 6, 0, 1, 0);
      push("R6 free wrap width", 0, 0, 16, 0);
      drain();

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule